// File: doc/BRIEF.md
# Round-Robin Execution Unit Selector

This block decides which unit of a multi-unit execution resource, or which member of a resource group, takes the next request. Each unit is named by a one-hot bit. A sequence mask holds the units that are still owed a turn in the current round. A dynamic request is granted the most significant unit left in that mask, and that unit's bit is then cleared. When the mask runs empty it is loaded again from the size mask, so the order repeats from the top.

A static request names one unit directly. That unit leaves the current round as well. If its bit had already gone, the unit goes into a removed mask, and it is skipped when the next round is loaded. In parallel, a ready mask shows which units are idle. Use and release strobes clear and set ready bits. The block compares the number of idle units with the number a caller needs and reports whether the resource is ready. A group counts as one unit. A plain resource counts as its number of units.

Top module: `rr_unit_selector`

## Requirements
- R1: After synchronous reset the sequence mask and the ready mask both equal the size mask, the removed mask is empty, and `ready_cnt` equals the popcount of the size mask.
- R2: With `dyn_req` high, `grant` shows in the same cycle the highest set bit of the sequence mask, and the sequence mask loses that bit at the next edge. With `dyn_req` low, `grant` is zero.
- R3: When the sequence mask would become zero, it is loaded with the size mask minus the removed bits, and the removed mask is cleared at that edge.
- R4: A static pick of unit k (bit k, for `stat_unit` = k) clears bit k from the sequence mask.
- R5: A static pick of a unit whose sequence bit is already clear sets that unit's bit in the removed mask. The unit is then excluded from the next loaded round, and only from that round.
- R6: If a dynamic grant and a static pick act in the same cycle, the dynamic grant is applied first. If the reload value after removal would be zero, the full size mask is loaded instead.
- R7: For a group, the size mask is `GROUP_MASK` with its highest set bit removed, and `unit_count` is 1.
- R8: For a plain resource of N units, the size mask is the lowest N bits, and `unit_count` is N.
- R9: `mark_en` with `mark_rel`=0 (use) clears the unit's ready bit. With `mark_rel`=1 (release) it sets the bit again. `ready_cnt` reflects the change after the next edge.
- R10: `ready` is high exactly when `ready_cnt` >= `need_units`.
- R11: Any of the following raises `err` in the same cycle and leaves the ready mask unchanged: using a unit that is not ready, releasing a unit that is ready, or marking a unit outside the size mask.
- R12: A static pick of a unit outside the size mask has no effect on the sequence mask or on the removed mask.
- R13: Reset asserted in the middle of operation restores the state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dyn_req | input | 1 | Request a dynamic selection |
| stat_req | input | 1 | Request a static pick of `stat_unit` |
| stat_unit | input | IDW | Index of the unit picked statically |
| mark_en | input | 1 | Strobe for a use or a release |
| mark_rel | input | 1 | 0 = use, 1 = release |
| mark_unit | input | IDW | Index of the unit used or released |
| need_units | input | CW | Number of idle units the caller needs |
| grant | output | W | One-hot unit granted to a dynamic request |
| ready | output | 1 | Enough idle units are available |
| ready_cnt | output | CW | Number of idle units |
| unit_count | output | CW | Unit count reported by the resource |
| err | output | 1 | The use or release just requested is illegal |

## Verification
A dynamic grant and a static pick can land in the same cycle, and the outcome depends on the order in which they are applied. The bench drives both requests in one cycle, with the static pick naming the unit that the dynamic grant takes. This is done once at the start of a round and once on the last unit, where all the other units are already in the removed mask. The grants that follow show the result. In the first case the round after the next reload skips that unit. In the second case the fallback reload of the full size mask starts again from the top unit.

// File: rtl/rr_sel_pkg.sv
package rr_sel_pkg;

    localparam int MAXW = 8;

    typedef logic [MAXW-1:0] umask_t;

    // isolate the most significant set bit
    function automatic umask_t top_bit(input umask_t m);
        umask_t r;
        r = '0;
        for (int i = 0; i < MAXW; i++) begin
            if (m[i]) r = umask_t'(1) << i;
        end
        return r;
    endfunction

    function automatic logic [3:0] pop8(input umask_t m);
        logic [3:0] c;
        c = '0;
        for (int i = 0; i < MAXW; i++) begin
            c = c + {3'b000, m[i]};
        end
        return c;
    endfunction

    // set of units the resource rotates over
    function automatic umask_t build_size(input logic grp, input umask_t gmask,
                                          input int n);
        umask_t r;
        r = '0;
        if (grp) begin
            r = gmask & ~top_bit(gmask);
        end else begin
            for (int i = 0; i < MAXW; i++) begin
                if (i < n) r[i] = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rr_seq_tracker.sv
module rr_seq_tracker
    import rr_sel_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] SIZE = '1,
    localparam int IDW = (W > 1) ? $clog2(W) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dyn_req,
    input  logic           stat_req,
    input  logic [IDW-1:0] stat_unit,
    output logic [W-1:0]   grant
);

    logic [W-1:0] seq_q, seq_d;
    logic [W-1:0] rem_q, rem_d;
    logic [W-1:0] dyn_bit, stat_bit;
    logic [W-1:0] after_dyn, after_stat, rem_mid, reload_val;

    always_comb begin
        umask_t wide;
        wide     = top_bit(umask_t'(seq_q));
        dyn_bit  = dyn_req ? wide[W-1:0] : '0;
        // a static pick outside the rotating set is dropped (R12)
        stat_bit = stat_req ? ((W'(1) << stat_unit) & SIZE) : '0;
        // dynamic grant is applied before the static pick (R6)
        after_dyn  = seq_q & ~dyn_bit;
        after_stat = after_dyn & ~stat_bit;
        rem_mid    = rem_q | (stat_bit & ~after_dyn);
        reload_val = SIZE & ~rem_mid;
        if (after_stat == '0) begin
            seq_d = (reload_val == '0) ? SIZE : reload_val;
            rem_d = '0;
        end else begin
            seq_d = after_stat;
            rem_d = rem_mid;
        end
    end

    assign grant = dyn_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SIZE;
            rem_q <= '0;
        end else begin
            seq_q <= seq_d;
            rem_q <= rem_d;
        end
    end

    a_r2_grant_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    a_r2_grant_leaves_seq: assert property (@(posedge clk) disable iff (rst)
        (dyn_req && !stat_req && $countones(seq_q) > 1) |=>
            ((seq_q & $past(grant)) == '0));

    a_r3_seq_never_empty: assert property (@(posedge clk) disable iff (rst)
        seq_q != '0);

    a_r5_removed_disjoint: assert property (@(posedge clk) disable iff (rst)
        (rem_q & seq_q) == '0);

    a_r12_within_size: assert property (@(posedge clk) disable iff (rst)
        ((seq_q | rem_q) & ~SIZE) == '0);

endmodule

// File: rtl/rr_ready_pool.sv
module rr_ready_pool
    import rr_sel_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] SIZE = '1,
    localparam int IDW = (W > 1) ? $clog2(W) : 1,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mark_en,
    input  logic           mark_rel,
    input  logic [IDW-1:0] mark_unit,
    output logic [CW-1:0]  ready_cnt,
    output logic           err
);

    logic [W-1:0] rdy_q, rdy_d;
    logic [W-1:0] mbit;
    logic         is_rdy, bad;

    always_comb begin
        mbit   = W'(1) << mark_unit;
        is_rdy = (rdy_q & mbit) != '0;
        bad    = ((mbit & SIZE) == '0) || (!mark_rel && !is_rdy) ||
                 (mark_rel && is_rdy);
        err    = mark_en && bad;
        rdy_d  = (mark_en && !bad) ? (rdy_q ^ mbit) : rdy_q;
    end

    always_comb begin
        logic [3:0] c;
        c         = pop8(umask_t'(rdy_q));
        ready_cnt = c[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) rdy_q <= SIZE;
        else     rdy_q <= rdy_d;
    end

    a_r11_err_holds_mask: assert property (@(posedge clk) disable iff (rst)
        err |=> $stable(rdy_q));

    a_r9_use_clears: assert property (@(posedge clk) disable iff (rst)
        (mark_en && !mark_rel && !err) |=> ((rdy_q & $past(mbit)) == '0));

    a_r9_release_sets: assert property (@(posedge clk) disable iff (rst)
        (mark_en && mark_rel && !err) |=> ((rdy_q & $past(mbit)) != '0));

    a_r11_ready_in_size: assert property (@(posedge clk) disable iff (rst)
        (rdy_q & ~SIZE) == '0);

endmodule

// File: rtl/rr_unit_selector.sv
module rr_unit_selector
    import rr_sel_pkg::*;
#(
    parameter int W = 8,
    parameter bit IS_GROUP = 1'b0,
    parameter int NUM_UNITS = 4,
    parameter logic [W-1:0] GROUP_MASK = '0,
    localparam int IDW = (W > 1) ? $clog2(W) : 1,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dyn_req,
    input  logic           stat_req,
    input  logic [IDW-1:0] stat_unit,
    input  logic           mark_en,
    input  logic           mark_rel,
    input  logic [IDW-1:0] mark_unit,
    input  logic [CW-1:0]  need_units,
    output logic [W-1:0]   grant,
    output logic           ready,
    output logic [CW-1:0]  ready_cnt,
    output logic           err
    ,
    output logic [CW-1:0]  unit_count
);

    localparam umask_t SIZE_W = build_size(IS_GROUP, umask_t'(GROUP_MASK), NUM_UNITS);
    localparam logic [W-1:0] SIZE = SIZE_W[W-1:0];
    localparam logic [3:0] SIZE_POP = pop8(SIZE_W);
    localparam logic [CW-1:0] UNITS = IS_GROUP ? CW'(1) : SIZE_POP[CW-1:0];

    rr_seq_tracker #(.W(W), .SIZE(SIZE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .dyn_req   (dyn_req),
        .stat_req  (stat_req),
        .stat_unit (stat_unit),
        .grant     (grant)
    );

    rr_ready_pool #(.W(W), .SIZE(SIZE)) u_pool (
        .clk       (clk),
        .rst       (rst),
        .mark_en   (mark_en),
        .mark_rel  (mark_rel),
        .mark_unit (mark_unit),
        .ready_cnt (ready_cnt),
        .err       (err)
    );

    assign ready      = (ready_cnt >= need_units);
    assign unit_count = UNITS;

    a_r10_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (ready_cnt == '0 && need_units != '0) |-> !ready);

    a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        ready_cnt <= CW'(SIZE_POP));

endmodule

// File: tb/tb_rr_unit_selector.sv
module tb_rr_unit_selector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dyn_req = 1'b0, stat_req = 1'b0, mark_en = 1'b0, mark_rel = 1'b0;
    logic [2:0] stat_unit = '0, mark_unit = '0;
    logic [3:0] need_units = '0;
    logic [7:0] grant, g_grant;
    logic       ready, err, g_ready, g_err;
    logic [3:0] ready_cnt, unit_count, g_cnt, g_units;

    int n_chk = 0, n_bad = 0;
    logic [7:0] s_grant, s_ggrant;
    logic       s_err;
    logic [3:0] s_cnt;

    always #5 clk = ~clk;

    rr_unit_selector #(.W(8), .IS_GROUP(1'b0), .NUM_UNITS(4)) dut (
        .clk(clk), .rst(rst), .dyn_req(dyn_req), .stat_req(stat_req),
        .stat_unit(stat_unit), .mark_en(mark_en), .mark_rel(mark_rel),
        .mark_unit(mark_unit), .need_units(need_units), .grant(grant),
        .ready(ready), .ready_cnt(ready_cnt), .err(err), .unit_count(unit_count));

    rr_unit_selector #(.W(8), .IS_GROUP(1'b1), .NUM_UNITS(1),
                       .GROUP_MASK(8'hB6)) dut_grp (
        .clk(clk), .rst(rst), .dyn_req(dyn_req), .stat_req(stat_req),
        .stat_unit(stat_unit), .mark_en(mark_en), .mark_rel(mark_rel),
        .mark_unit(mark_unit), .need_units(need_units), .grant(g_grant),
        .ready(g_ready), .ready_cnt(g_cnt), .err(g_err), .unit_count(g_units));

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // drive one cycle; capture outputs just after the falling edge
    task automatic step(input logic d, input logic s, input int su,
                        input logic m, input logic rl, input int mu);
        @(negedge clk);
        dyn_req = d; stat_req = s; stat_unit = 3'(su);
        mark_en = m; mark_rel = rl; mark_unit = 3'(mu);
        #1;
        s_grant = grant; s_ggrant = g_grant; s_err = err; s_cnt = ready_cnt;
    endtask

    task automatic dyn(input string req, input int exp);
        step(1, 0, 0, 0, 0, 0);
        chk(req, s_grant, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        step(0, 0, 0, 0, 0, 0);
        chk("R1 ready_cnt", s_cnt, 4);
        chk("R2 no request grant", s_grant, 0);
        chk("R8 unit_count", unit_count, 4);
    endtask

    task automatic t_order();
        do_reset();
        dyn("R2 first", 8'h08); dyn("R2 second", 8'h04);
        dyn("R2 third", 8'h02); dyn("R2 fourth", 8'h01);
        dyn("R3 reload", 8'h08);
    endtask

    task automatic t_static();
        do_reset();
        step(0, 1, 2, 0, 0, 0);
        dyn("R4 a", 8'h08); dyn("R4 skip unit2", 8'h02);
        dyn("R4 c", 8'h01); dyn("R4 reload", 8'h08);
    endtask

    task automatic t_removed();
        do_reset();
        dyn("R5 a", 8'h08);
        step(0, 1, 3, 0, 0, 0);
        dyn("R5 b", 8'h04); dyn("R5 c", 8'h02); dyn("R5 d", 8'h01);
        dyn("R5 excluded round", 8'h04); dyn("R5 e", 8'h02); dyn("R5 f", 8'h01);
        dyn("R5 removed cleared", 8'h08);
    endtask

    task automatic t_collide();
        do_reset();
        step(1, 1, 3, 0, 0, 0);
        chk("R6 collide grant", s_grant, 8'h08);
        dyn("R6 a", 8'h04); dyn("R6 b", 8'h02); dyn("R6 c", 8'h01);
        dyn("R6 collided unit skipped", 8'h04);
        do_reset();
        dyn("R6 g", 8'h08); dyn("R6 h", 8'h04); dyn("R6 i", 8'h02);
        step(0, 1, 3, 0, 0, 0); step(0, 1, 2, 0, 0, 0); step(0, 1, 1, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0);
        chk("R6 last unit grant", s_grant, 8'h01);
        dyn("R6 full fallback", 8'h08);
    endtask

    task automatic t_outside();
        do_reset();
        step(0, 1, 6, 0, 0, 0);
        dyn("R12 a", 8'h08); dyn("R12 b", 8'h04); dyn("R12 c", 8'h02);
        dyn("R12 d", 8'h01); dyn("R12 reload", 8'h08);
    endtask

    task automatic t_ready();
        do_reset();
        step(0, 0, 0, 1, 0, 1);
        chk("R9 use no err", s_err, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R9 cnt after use", s_cnt, 3);
        need_units = 4'd4; #1;
        chk("R10 need 4", ready, 0);
        need_units = 4'd3; #1;
        chk("R10 need 3", ready, 1);
        step(0, 0, 0, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0);
        chk("R9 cnt after release", s_cnt, 4);
        need_units = 4'd5; #1;
        chk("R10 need 5", ready, 0);
        need_units = 4'd0;
    endtask

    task automatic t_err();
        do_reset();
        step(0, 0, 0, 1, 0, 2);
        step(0, 0, 0, 1, 0, 2);
        chk("R11 double use err", s_err, 1);
        chk("R9 cnt", s_cnt, 3);
        step(0, 0, 0, 1, 1, 0);
        chk("R11 release ready err", s_err, 1);
        chk("R11 cnt after double use", s_cnt, 3);
        step(0, 0, 0, 1, 0, 5);
        chk("R11 outside err", s_err, 1);
        chk("R11 cnt after bad release", s_cnt, 3);
        step(0, 0, 0, 0, 0, 0);
        chk("R11 cnt unchanged", s_cnt, 3);
    endtask

    task automatic t_group();
        do_reset();
        step(0, 0, 0, 0, 0, 0);
        chk("R7 group count", g_units, 1);
        chk("R7 group idle units", g_cnt, 4);
        step(1, 0, 0, 0, 0, 0); chk("R7 g1", s_ggrant, 8'h20);
        step(1, 0, 0, 0, 0, 0); chk("R7 g2", s_ggrant, 8'h10);
        step(1, 0, 0, 0, 0, 0); chk("R7 g3", s_ggrant, 8'h04);
        step(1, 0, 0, 0, 0, 0); chk("R7 g4", s_ggrant, 8'h02);
        step(1, 0, 0, 0, 0, 0); chk("R7 reload", s_ggrant, 8'h20);
    endtask

    task automatic t_midreset();
        do_reset();
        dyn("R13 pre", 8'h08);
        step(0, 0, 0, 1, 0, 0);
        do_reset();
        step(0, 0, 0, 0, 0, 0);
        chk("R13 cnt", s_cnt, 4);
        dyn("R13 grant", 8'h08);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_order(); t_static(); t_removed(); t_collide();
                t_outside(); t_ready(); t_err(); t_group(); t_midreset();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule